// File: doc/BRIEF.md
# SDRAM Page-Hit and Dynamic-Energy Monitor

This block watches a stream of memory requests without taking part in them. Each request names a bank and a row. The monitor remembers which row is open in every bank, if any. From that it decides whether each access is a page hit or a page miss, and which command sequence the bank would need:

- a column access alone;
- activation followed by a column access;
- precharge, then activation, then a column access.

It keeps running counts of hits, misses and accesses. It also keeps a dynamic-energy total in picojoules: every access costs 2000 pJ, and every miss costs a further 14000 pJ.

Requests use a valid/ready handshake, and at most one access is taken per clock. A synchronous clear empties the counters and the energy total and forgets every open row. The classification for an accepted access appears on the outputs one cycle after acceptance. It stays there for that single cycle, together with the command sequence.

Top module: `pagehit_energy_mon`

## Requirements
- R1: After reset or after a cycle with `clr` high, the hit, miss and access counts and the energy total read zero. Every bank holds no open row, so the next access to any bank is a miss.
- R2: An access whose row equals the open row of its bank is a hit. It yields `cls_miss`=0 and `cmd_seq`=2'b01 (column only), adds one to the hit count and adds 2000 pJ.
- R3: An access to a bank that has a different row open is a miss with `cmd_seq`=2'b11 (precharge, activate, column). It adds one to the miss count and 16000 pJ, and its row becomes the bank's open row.
- R4: An access to a bank with no open row is a miss with `cmd_seq`=2'b10 (activate, column). It is costed like any other miss.
- R5: A request is accepted when `req_valid` and `req_ready` are both high, so at most one is accepted per cycle. `req_ready` is low while `clr` is high, and a request offered in that cycle is not counted.
- R6: In the cycle after each accepted access, `cls_valid` is high with `cls_miss` and `cmd_seq` for that access. In a cycle after no acceptance, `cls_valid` is low and `cmd_seq` is 2'b00.
- R7: The energy total saturates at its all-ones value (width ENERGY_W, default 48) instead of wrapping.
- R8: An access changes only the open row of its own bank.
- R9: The access count always equals the sum of the hit and miss counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of counts, energy and open rows |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bank | input | $clog2(NUM_BANKS) | Bank index |
| req_row | input | ROW_W | Row address |
| cls_valid | output | 1 | Classification present (one cycle per access) |
| cls_miss | output | 1 | 1 = page miss, 0 = page hit |
| cmd_seq | output | 2 | 00 none, 01 column, 10 activate+column, 11 precharge+activate+column |
| cnt_hit | output | CNT_W | Hits since reset or clear |
| cnt_miss | output | CNT_W | Misses since reset or clear |
| cnt_total | output | CNT_W | Accesses since reset or clear |
| energy_pj | output | ENERGY_W | Saturating dynamic energy in pJ |

## Verification
Two events can land on one clock edge: a lookup of a bank's open row and the update of that row by the previous access. This is provoked by back-to-back accesses to the same bank that alternate between a repeated row and a new row. A fresh access can also meet a clear: the bench offers a request in the same cycle that `clr` is raised. Each case is judged by the scoreboard's expected classification and by the counts and energy read after the stream goes idle. The request that meets the clear must be neither classified nor counted.

// File: rtl/pagemon_pkg.sv
package pagemon_pkg;
  typedef enum logic [1:0] {
    SEQ_NONE        = 2'b00,
    SEQ_COL         = 2'b01,
    SEQ_ACT_COL     = 2'b10,
    SEQ_PRE_ACT_COL = 2'b11
  } seq_e;

  localparam int unsigned MISS_COST_PJ   = 14000;
  localparam int unsigned ACCESS_COST_PJ = 2000;
endpackage

// File: rtl/pm_bank_table.sv
module pm_bank_table #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd_en,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  output logic              was_open,
  output logic              hit
);
  logic             vld_q [NUM_BANKS];
  logic             vld_d [NUM_BANKS];
  logic [ROW_W-1:0] row_q [NUM_BANKS];
  logic [ROW_W-1:0] row_d [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = upd_en && (bank == BANK_W'(b));

    always_comb begin
      vld_d[b] = vld_q[b];
      row_d[b] = row_q[b];
      if (clr) begin
        vld_d[b] = 1'b0;
      end else if (sel) begin
        vld_d[b] = 1'b1;
        row_d[b] = row;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[b] <= 1'b0;
        row_q[b] <= '0;
      end else begin
        vld_q[b] <= vld_d[b];
        row_q[b] <= row_d[b];
      end
    end
  end

  assign was_open = vld_q[bank];
  assign hit      = vld_q[bank] && (row_q[bank] == row);
endmodule

// File: rtl/pm_evt_cnt.sv
module pm_evt_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/pm_energy_acc.sv
module pm_energy_acc #(
  parameter int W            = 48,
  parameter int unsigned MISS_PJ = 14000,
  parameter int unsigned ACC_PJ  = 2000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         miss,
  output logic [W-1:0] total
);
  localparam logic [W:0] INC_HIT  = (W+1)'(ACC_PJ);
  localparam logic [W:0] INC_MISS = (W+1)'(ACC_PJ + MISS_PJ);

  logic [W:0]   sum;
  logic [W-1:0] total_d;

  always_comb begin
    sum     = {1'b0, total} + (miss ? INC_MISS : INC_HIT);
    total_d = total;
    if (clr)     total_d = '0;
    else if (en) total_d = sum[W] ? {W{1'b1}} : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) total <= '0;
    else        total <= total_d;
  end
endmodule

// File: rtl/pagehit_energy_mon.sv
module pagehit_energy_mon
  import pagemon_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 12,
  parameter int CNT_W     = 32,
  parameter int ENERGY_W  = 48,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]    req_row,
  output logic                cls_valid,
  output logic                cls_miss,
  output logic [1:0]          cmd_seq,
  output logic [CNT_W-1:0]    cnt_hit,
  output logic [CNT_W-1:0]    cnt_miss,
  output logic [CNT_W-1:0]    cnt_total,
  output logic [ENERGY_W-1:0] energy_pj
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run = rst_sync_q[1];

  logic accept, hit, was_open;
  assign req_ready = run && !clr;
  assign accept    = req_valid && req_ready;

  pm_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd_en(accept),
    .bank(req_bank), .row(req_row), .was_open(was_open), .hit(hit)
  );

  // event counters: [0] total, [1] hit, [2] miss
  logic [2:0]            evt;
  logic [CNT_W-1:0]      cnt_arr [3];
  assign evt = {accept && !hit, accept && hit, accept};

  for (genvar i = 0; i < 3; i++) begin : g_cnt
    pm_evt_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(evt[i]), .cnt(cnt_arr[i])
    );
  end
  assign cnt_total = cnt_arr[0];
  assign cnt_hit   = cnt_arr[1];
  assign cnt_miss  = cnt_arr[2];

  pm_energy_acc #(.W(ENERGY_W), .MISS_PJ(MISS_COST_PJ), .ACC_PJ(ACCESS_COST_PJ)) u_nrg (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(accept), .miss(!hit), .total(energy_pj)
  );

  // classification stage
  logic cls_valid_d, cls_miss_d;
  seq_e seq_d, seq_q;

  always_comb begin
    cls_valid_d = accept;
    cls_miss_d  = accept && !hit;
    if (!accept)      seq_d = SEQ_NONE;
    else if (hit)     seq_d = SEQ_COL;
    else if (was_open) seq_d = SEQ_PRE_ACT_COL;
    else              seq_d = SEQ_ACT_COL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_valid <= 1'b0;
      cls_miss  <= 1'b0;
      seq_q     <= SEQ_NONE;
    end else begin
      cls_valid <= cls_valid_d;
      cls_miss  <= cls_miss_d;
      seq_q     <= seq_d;
    end
  end
  assign cmd_seq = seq_q;
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int CNT_W    = 32,
  parameter int ENERGY_W = 48
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr,
  input logic                req_valid,
  input logic                req_ready,
  input logic                cls_valid,
  input logic                cls_miss,
  input logic [1:0]          cmd_seq,
  input logic [CNT_W-1:0]    cnt_hit,
  input logic [CNT_W-1:0]    cnt_miss,
  input logic [CNT_W-1:0]    cnt_total,
  input logic [ENERGY_W-1:0] energy_pj
);
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_total == '0 && cnt_hit == '0 && cnt_miss == '0 && energy_pj == '0));

  a_r2_hit_col_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && !cls_miss) |-> (cmd_seq == 2'b01));

  a_r3_miss_activates: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls_miss) |-> cmd_seq[1]);

  a_r5_ready_low_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !req_ready);

  a_r6_pulse_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cls_valid);

  a_r6_quiet_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (!cls_valid && cmd_seq == 2'b00));

  a_r7_energy_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (energy_pj >= $past(energy_pj)));

  a_r9_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_total == cnt_hit + cnt_miss);
endmodule

bind pagehit_energy_mon pm_checker #(.CNT_W(CNT_W), .ENERGY_W(ENERGY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .req_valid(req_valid), .req_ready(req_ready),
  .cls_valid(cls_valid), .cls_miss(cls_miss), .cmd_seq(cmd_seq),
  .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_total(cnt_total), .energy_pj(energy_pj)
);

// File: tb/sim_pagehit_energy_mon.sv
module sim_pagehit_energy_mon;
  localparam int NB = 8;
  localparam int RW = 12;
  localparam int CW = 32;
  localparam int EW = 20;
  localparam longint EMAX = (64'd1 << EW) - 1;

  logic clk = 1'b0;
  logic rst_n, clr, req_valid, req_ready, cls_valid, cls_miss;
  logic [2:0] req_bank;
  logic [RW-1:0] req_row;
  logic [1:0] cmd_seq;
  logic [CW-1:0] cnt_hit, cnt_miss, cnt_total;
  logic [EW-1:0] energy_pj;

  always #10 clk = ~clk;

  pagehit_energy_mon #(.NUM_BANKS(NB), .ROW_W(RW), .CNT_W(CW), .ENERGY_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .cls_valid(cls_valid), .cls_miss(cls_miss),
    .cmd_seq(cmd_seq), .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_total(cnt_total),
    .energy_pj(energy_pj)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // scoreboard item: {miss, cmd_seq}
  logic [2:0] sb_q[$];

  // reference model
  bit     m_vld [NB];
  int     m_row [NB];
  longint m_hit, m_miss, m_nrg;

  task automatic model_clear();
    for (int b = 0; b < NB; b++) m_vld[b] = 0;
    m_hit = 0; m_miss = 0; m_nrg = 0;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: offers one access and pushes its expected classification
  task automatic send(input int b, input int r);
    logic [1:0] seq;
    bit miss;
    @(negedge clk);
    req_valid = 1'b1;
    req_bank  = 3'(b);
    req_row   = RW'(r);
    if (m_vld[b] && m_row[b] == r) begin miss = 0; seq = 2'b01; end   // R2
    else if (m_vld[b])             begin miss = 1; seq = 2'b11; end   // R3
    else                           begin miss = 1; seq = 2'b10; end   // R4
    sb_q.push_back({miss, seq});
    m_vld[b] = 1; m_row[b] = r;
    if (miss) begin m_miss++; m_nrg += 16000; end
    else      begin m_hit++;  m_nrg += 2000;  end
    if (m_nrg > EMAX) m_nrg = EMAX;                                    // R7
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic chk_counts(input string tag);
    chk({tag, " R2 hit count"}, cnt_hit, m_hit);
    chk({tag, " R3 miss count"}, cnt_miss, m_miss);
    chk({tag, " R9 total count"}, cnt_total, m_hit + m_miss);
    chk({tag, " R7 energy"}, energy_pj, m_nrg);
  endtask

  // monitor: compares every classification against the scoreboard (R6)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cls_valid) begin
        total++;
        if (sb_q.size() == 0) begin
          bad++;
          $display("FAIL R6 unexpected cls actual=%b%b expected=none", cls_miss, cmd_seq);
        end else begin
          logic [2:0] e;
          e = sb_q.pop_front();
          if ({cls_miss, cmd_seq} != e) begin
            bad++;
            $display("FAIL R2/R3/R4 class actual=%b expected=%b", {cls_miss, cmd_seq}, e);
          end
        end
      end else if (cmd_seq != 2'b00) begin
        total++; bad++;
        $display("FAIL R6 cmd_seq idle actual=%b expected=00", cmd_seq);
      end
    end
  end

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; req_valid = 1'b0; req_bank = '0; req_row = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_counts("R1 reset");
    chk("R1 cls_valid after reset", cls_valid, 0);
    chk("R5 ready idle", req_ready, 1);

    // R4, R2, R3, R8 back-to-back on shared and separate banks
    send(0, 5); send(0, 5); send(0, 9); send(1, 9); send(0, 9);
    send(1, 9); send(1, 4); send(1, 9);
    idle(2);
    chk_counts("mixed");

    // every bank opened then revisited (R8 independence)
    for (int b = 0; b < NB; b++) send(b, b * 3 + 100);
    for (int b = NB - 1; b >= 0; b--) send(b, b * 3 + 100);
    idle(2);
    chk_counts("all banks");

    // R5 clear meets a request; R1 rows forgotten
    @(negedge clk);
    clr = 1'b1; req_valid = 1'b1; req_bank = 3'd0; req_row = 12'd9;
    #1 chk("R5 ready during clear", req_ready, 0);
    @(negedge clk);
    clr = 1'b0; req_valid = 1'b0;
    model_clear();
    chk_counts("R1 after clear");
    send(0, 9);
    idle(2);
    chk_counts("R1 first after clear");

    // R7 saturation: 70 misses on bank 2
    for (int k = 0; k < 70; k++) send(2, k);
    idle(2);
    chk("R7 energy saturated", energy_pj, EMAX);
    chk_counts("R7 sat");
    send(2, 69);
    idle(2);
    chk("R7 held at max after hit", energy_pj, EMAX);
    chk("R6 scoreboard drained", sb_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule